// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block translates a 32-bit effective address through segment registers and a hashed page table in memory. It is used when the block-translation path has missed. The engine keeps sixteen 32-bit segment registers and a 32-bit table descriptor, both loaded through simple write strobes. For each accepted request it does the following:

- It takes the segment register chosen by the top address bits.
- It forms a 19-bit hash and from it the address of an eight-entry group.
- It fetches the 64-bit entries of that group one at a time over a request/valid read port.

If no entry in the primary group matches, it searches a second group found through the complemented hash. A hit returns the real address, the four storage-control bits, the two protection bits and the selected storage key. A double miss returns a page fault tagged with the access type. A segment register marked as direct-store faults at once and reads no memory.

Bits are numbered here with bit 0 as the least significant bit. A block-translation hit that arrives together with a request wins over this engine: the engine does not accept that request.

Top module: `hpt_search`

## Requirements
- R1: Address bits [31:28] choose the segment register. Its virtual segment ID is bits [23:0], its direct-store flag is bit 31, its supervisor key is bit 30 and its problem-state key is bit 29.
- R2: With hash = VSID[18:0] XOR {3'b0, EA[27:12]}, the group address is {D[31:25], (hash[18:10] AND D[8:0]) OR D[24:16], hash[9:0], 6'b0}, where D is the table descriptor.
- R3: Each read returns 64 bits. The upper word holds valid in bit 31, VSID in [30:7], the secondary flag in bit 6 and the abbreviated index in [5:0]. An entry matches only when it is valid, its VSID equals the segment VSID, its secondary flag equals the current pass (0 primary, 1 secondary), and its abbreviated index equals EA[27:22].
- R4: Entries are read at group address + 8*i for i = 0 up to 7, in order. The search stops at the first matching entry.
- R5: After eight primary misses, the engine searches the group given by the bitwise complement of the hash, again from entry 0.
- R6: On a hit, the real address is {lower word [31:12], EA[11:0]}, the storage-control bits are lower word [6:3] and the protection bits are lower word [1:0].
- R7: When both passes miss, the engine reports a fault after 16 reads. The fetch tag is 1 for an instruction access and 0 for a data access.
- R8: A segment register with bit 31 set gives a fault with the direct-store flag set and issues no memory read.
- R9: A request presented with blockHit high is dropped: no busy, no response, no read.
- R10: busy is high in every cycle after acceptance until the response cycle. rspValid is a one-cycle pulse with busy low.
- R11: rspKey is the problem-state key when the request was in problem state, and the supervisor key otherwise.
- R12: memReq is a one-cycle pulse, raised only while busy, with at most one read outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWe | input | 1 | Segment register write strobe |
| segSel | input | 4 | Segment register index for the write |
| segWdata | input | 32 | Segment register write data |
| descWe | input | 1 | Table descriptor write strobe |
| descWdata | input | 32 | Table descriptor write data |
| reqValid | input | 1 | Translation request, taken when idle |
| reqEa | input | 32 | Effective address |
| reqFetch | input | 1 | 1 for instruction access, 0 for data |
| reqProblem | input | 1 | 1 for problem (user) state |
| blockHit | input | 1 | Block translation hit for this request |
| busy | output | 1 | Search in progress |
| memReq | output | 1 | Entry read request pulse |
| memAddr | output | 32 | Entry read address |
| memValid | input | 1 | Read data valid |
| memData | input | 64 | Entry, upper word first |
| rspValid | output | 1 | Result pulse |
| rspFault | output | 1 | Translation failed |
| rspFetch | output | 1 | Fault belongs to an instruction access |
| rspDirectStore | output | 1 | Fault caused by a direct-store segment |
| rspRa | output | 32 | Real address |
| rspWimg | output | 4 | Storage-control bits |
| rspPp | output | 2 | Protection bits |
| rspKey | output | 1 | Selected storage key |

## Verification
The bench builds the engine with its default parameters: sixteen segment registers and eight entries per group. At that size a full double miss costs only sixteen reads, so every exhaustive search path runs in a few dozen cycles. The descriptor is varied between a zero mask, a full mask and a partial mask with OR bits, which brings the masked upper hash bits into the group address. Decoy entries that fail one match field at a time test each field in the match rule in isolation.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int EA_W   = 32;
  localparam int HASH_W = 19;

  // strobes from control into datapath
  typedef struct packed {
    logic accept;
    logic captureDirect;
    logic nextEntry;
    logic goSecondary;
    logic captureHit;
    logic captureMiss;
  } hptCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic directIn;
    logic match;
    logic lastEntry;
    logic secondary;
  } hptStat_t;
endpackage

// File: rtl/hpt_datapath.sv
module hpt_datapath
  import hpt_pkg::*;
#(
  parameter int SEG_COUNT     = 16,
  parameter int GROUP_ENTRIES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         segWe,
  input  logic [$clog2(SEG_COUNT)-1:0] segSel,
  input  logic [31:0]                  segWdata,
  input  logic                         descWe,
  input  logic [31:0]                  descWdata,
  input  logic [EA_W-1:0]              reqEa,
  input  logic                         reqFetch,
  input  logic                         reqProblem,
  input  logic [63:0]                  memData,
  input  hptCtrl_t                     ctrl,
  output hptStat_t                     stat,
  output logic [EA_W-1:0]              memAddr,
  output logic [EA_W-1:0]              rspRa,
  output logic [3:0]                   rspWimg,
  output logic [1:0]                   rspPp,
  output logic                         rspKey,
  output logic                         rspFault,
  output logic                         rspFetch,
  output logic                         rspDirectStore
);
  localparam int SEG_IDX_W   = $clog2(SEG_COUNT);
  localparam int ENTRY_IDX_W = $clog2(GROUP_ENTRIES);
  localparam int ENTRY_SHIFT = 3;
  localparam int PAD_W       = EA_W - ENTRY_IDX_W - ENTRY_SHIFT;

  logic [31:0] segRegs [SEG_COUNT];
  logic [31:0] descQ;

  // segment register file
  for (genvar g = 0; g < SEG_COUNT; g++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN)
        segRegs[g] <= '0;
      else if (segWe && segSel == SEG_IDX_W'(g))
        segRegs[g] <= segWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      descQ <= '0;
    else if (descWe)
      descQ <= descWdata;
  end

  logic [31:0] segIn;
  assign segIn = segRegs[reqEa[EA_W-1 -: SEG_IDX_W]];
  assign stat.directIn = segIn[31];

  // per-request state
  logic [27:0]            eaQ;
  logic [23:0]            vsidQ;
  logic                   secondaryQ;
  logic [ENTRY_IDX_W-1:0] idxQ;
  logic [EA_W-1:0]        raQ;
  logic [3:0]             wimgQ;
  logic [1:0]             ppQ;
  logic                   keyQ, faultQ, fetchQ, directQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ        <= '0;
      vsidQ      <= '0;
      secondaryQ <= 1'b0;
      idxQ       <= '0;
      raQ        <= '0;
      wimgQ      <= '0;
      ppQ        <= '0;
      keyQ       <= 1'b0;
      faultQ     <= 1'b0;
      fetchQ     <= 1'b0;
      directQ    <= 1'b0;
    end else begin
      if (ctrl.accept) begin
        eaQ        <= reqEa[27:0];
        vsidQ      <= segIn[23:0];
        secondaryQ <= 1'b0;
        idxQ       <= '0;
        keyQ       <= reqProblem ? segIn[29] : segIn[30];
        fetchQ     <= reqFetch;
        faultQ     <= 1'b0;
        directQ    <= 1'b0;
      end
      if (ctrl.captureDirect) begin
        faultQ  <= 1'b1;
        directQ <= 1'b1;
      end
      if (ctrl.nextEntry)
        idxQ <= idxQ + 1'b1;
      if (ctrl.goSecondary) begin
        secondaryQ <= 1'b1;
        idxQ       <= '0;
      end
      if (ctrl.captureHit) begin
        raQ   <= {memData[31:12], eaQ[11:0]};
        wimgQ <= memData[6:3];
        ppQ   <= memData[1:0];
      end
      if (ctrl.captureMiss)
        faultQ <= 1'b1;
    end
  end

  // hash and group address
  logic [HASH_W-1:0] primaryHash, activeHash;
  logic [8:0]        midBits;
  logic [EA_W-1:0]   groupBase;

  always_comb begin
    primaryHash = vsidQ[HASH_W-1:0] ^ {3'b000, eaQ[27:12]};
    activeHash  = secondaryQ ? ~primaryHash : primaryHash;
    midBits     = (activeHash[18:10] & descQ[8:0]) | descQ[24:16];
    groupBase   = {descQ[31:25], midBits, activeHash[9:0], 6'b000000};
    memAddr     = groupBase | {{PAD_W{1'b0}}, idxQ, {ENTRY_SHIFT{1'b0}}};
  end

  // entry compare
  logic [31:0] word0;
  assign word0 = memData[63:32];
  assign stat.match = word0[31] && (word0[30:7] == vsidQ) &&
                      (word0[6] == secondaryQ) && (word0[5:0] == eaQ[27:22]);
  assign stat.lastEntry = (idxQ == ENTRY_IDX_W'(GROUP_ENTRIES - 1));
  assign stat.secondary = secondaryQ;

  logic unusedBits;
  assign unusedBits = ^{memData[11:7], memData[2], descQ[15:9], segIn[28:24]};

  assign rspRa          = raQ;
  assign rspWimg        = wimgQ;
  assign rspPp          = ppQ;
  assign rspKey         = keyQ;
  assign rspFault       = faultQ;
  assign rspFetch       = faultQ & fetchQ;
  assign rspDirectStore = directQ;
endmodule

// File: rtl/hpt_control.sv
module hpt_control
  import hpt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     blockHit,
  input  logic     memValid,
  input  hptStat_t stat,
  output hptCtrl_t ctrl,
  output logic     memReq,
  output logic     busy,
  output logic     rspValid
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_RESP} state_t;
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid && !blockHit) begin
          ctrl.accept        = 1'b1;
          ctrl.captureDirect = stat.directIn;
          stateNext          = stat.directIn ? S_RESP : S_REQ;
        end
      end
      S_REQ: stateNext = S_WAIT;
      S_WAIT: begin
        if (memValid) begin
          if (stat.match) begin
            ctrl.captureHit = 1'b1;
            stateNext       = S_RESP;
          end else if (!stat.lastEntry) begin
            ctrl.nextEntry = 1'b1;
            stateNext      = S_REQ;
          end else if (!stat.secondary) begin
            ctrl.goSecondary = 1'b1;
            stateNext        = S_REQ;
          end else begin
            ctrl.captureMiss = 1'b1;
            stateNext        = S_RESP;
          end
        end
      end
      S_RESP: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign memReq   = (state == S_REQ);
  assign busy     = (state == S_REQ) || (state == S_WAIT);
  assign rspValid = (state == S_RESP);
endmodule

// File: rtl/hpt_search.sv
module hpt_search
  import hpt_pkg::*;
#(
  parameter int SEG_COUNT     = 16,
  parameter int GROUP_ENTRIES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         segWe,
  input  logic [$clog2(SEG_COUNT)-1:0] segSel,
  input  logic [31:0]                  segWdata,
  input  logic                         descWe,
  input  logic [31:0]                  descWdata,
  input  logic                         reqValid,
  input  logic [31:0]                  reqEa,
  input  logic                         reqFetch,
  input  logic                         reqProblem,
  input  logic                         blockHit,
  output logic                         busy,
  output logic                         memReq,
  output logic [31:0]                  memAddr,
  input  logic                         memValid,
  input  logic [63:0]                  memData,
  output logic                         rspValid,
  output logic                         rspFault,
  output logic                         rspFetch,
  output logic                         rspDirectStore,
  output logic [31:0]                  rspRa,
  output logic [3:0]                   rspWimg,
  output logic [1:0]                   rspPp,
  output logic                         rspKey
);
  hptCtrl_t ctrl;
  hptStat_t stat;

  hpt_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .blockHit(blockHit),
    .memValid(memValid), .stat(stat), .ctrl(ctrl), .memReq(memReq),
    .busy(busy), .rspValid(rspValid)
  );

  hpt_datapath #(.SEG_COUNT(SEG_COUNT), .GROUP_ENTRIES(GROUP_ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .segWe(segWe), .segSel(segSel), .segWdata(segWdata),
    .descWe(descWe), .descWdata(descWdata), .reqEa(reqEa), .reqFetch(reqFetch),
    .reqProblem(reqProblem), .memData(memData), .ctrl(ctrl), .stat(stat),
    .memAddr(memAddr), .rspRa(rspRa), .rspWimg(rspWimg), .rspPp(rspPp),
    .rspKey(rspKey), .rspFault(rspFault), .rspFetch(rspFetch),
    .rspDirectStore(rspDirectStore)
  );
endmodule

// File: rtl/hpt_search_chk.sv
module hpt_search_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic blockHit,
  input logic busy,
  input logic rspValid,
  input logic rspFault,
  input logic rspDirectStore,
  input logic memReq
);
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  p_busy_low_at_rsp_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !busy);
  p_memreq_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  p_memreq_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);
  p_direct_is_fault_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspDirectStore) |-> rspFault);
  p_block_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !rspValid && reqValid && blockHit) |=> (!busy && !rspValid));
endmodule

bind hpt_search hpt_search_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .blockHit(blockHit),
  .busy(busy), .rspValid(rspValid), .rspFault(rspFault),
  .rspDirectStore(rspDirectStore), .memReq(memReq)
);

// File: tb/hpt_search_tb.sv
`timescale 1ns/1ps
module hpt_search_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        segWe = 0, descWe = 0, reqValid = 0, reqFetch = 0, reqProblem = 0, blockHit = 0;
  logic [3:0]  segSel = 0;
  logic [31:0] segWdata = 0, descWdata = 0, reqEa = 0;
  logic        busy, memReq, memValid, rspValid, rspFault, rspFetch, rspDirectStore, rspKey;
  logic [31:0] memAddr, rspRa;
  logic [63:0] memData;
  logic [3:0]  rspWimg;
  logic [1:0]  rspPp;

  hpt_search u_dut (.*);

  int tests = 0, fails = 0;
  bit finished = 0;

  // sparse memory model
  logic [31:0] tabAddr [64];
  logic [63:0] tabData [64];
  int tabCount = 0;
  int readCount = 0;

  function automatic logic [63:0] lookup(input logic [31:0] a);
    for (int i = 0; i < 64; i++)
      if (i < tabCount && tabAddr[i] == a) return tabData[i];
    return 64'h0;
  endfunction

  initial begin
    memValid = 1'b0;
    memData  = '0;
  end
  always @(posedge clk) begin
    memValid <= memReq;
    memData  <= lookup(memAddr);
    if (memReq) readCount <= readCount + 1;
  end

  task automatic put(input logic [31:0] a, input logic [63:0] d);
    tabAddr[tabCount] = a;
    tabData[tabCount] = d;
    tabCount++;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] grp(input logic [31:0] d, input logic [23:0] vsid,
                                      input logic [31:0] ea, input bit sec);
    logic [18:0] h;
    h = vsid[18:0] ^ {3'b000, ea[27:12]};
    if (sec) h = ~h;
    return {d[31:25], (h[18:10] & d[8:0]) | d[24:16], h[9:0], 6'b0};
  endfunction

  function automatic logic [63:0] pte(input bit v, input logic [23:0] vsid, input bit h,
                                      input logic [5:0] api, input logic [19:0] rpn,
                                      input logic [3:0] wimg, input logic [1:0] pp);
    return {v, vsid, h, api, rpn, 3'b000, 2'b11, wimg, 1'b0, pp};
  endfunction

  task automatic wrSeg(input int idx, input logic [31:0] v);
    @(negedge clk); segWe = 1; segSel = 4'(idx); segWdata = v;
    @(negedge clk); segWe = 0;
  endtask

  task automatic wrDesc(input logic [31:0] v);
    @(negedge clk); descWe = 1; descWdata = v;
    @(negedge clk); descWe = 0;
  endtask

  logic [31:0] gotRa;
  logic [3:0]  gotWimg;
  logic [1:0]  gotPp;
  logic        gotFault, gotFetch, gotDirect, gotKey;
  int          gotReads;
  bit          busyGap;

  task automatic run(input logic [31:0] ea, input bit fetch, input bit prob);
    int startReads, cyc;
    @(negedge clk);
    startReads = readCount;
    reqValid = 1; reqEa = ea; reqFetch = fetch; reqProblem = prob;
    @(negedge clk);
    reqValid = 0;
    busyGap = 0;
    cyc = 0;
    while (!rspValid && cyc < 200) begin
      if (!busy) busyGap = 1;
      @(negedge clk);
      cyc++;
    end
    chk("R10 response seen", {31'b0, rspValid}, 32'd1);
    chk("R10 busy low in response cycle", {31'b0, busy}, 32'd0);
    gotRa = rspRa; gotWimg = rspWimg; gotPp = rspPp; gotFault = rspFault;
    gotFetch = rspFetch; gotDirect = rspDirectStore; gotKey = rspKey;
    gotReads = readCount - startReads;
    @(negedge clk);
    chk("R10 response is one cycle", {31'b0, rspValid}, 32'd0);
  endtask

  localparam logic [31:0] DESC0 = 32'h0A00_0000;
  localparam logic [23:0] VS3   = 24'h0D2345;
  localparam logic [23:0] VS7   = 24'h0ABCDE;

  task automatic tReset;
    chk("R10 busy after reset", {31'b0, busy}, 32'd0);
    chk("R10 rspValid after reset", {31'b0, rspValid}, 32'd0);
    chk("R12 memReq after reset", {31'b0, memReq}, 32'd0);
  endtask

  task automatic tPrimaryFirst;
    logic [31:0] ea = 32'h3ABC_D123;
    tabCount = 0;
    put(grp(DESC0, VS3, ea, 0), pte(1, VS3, 0, ea[27:22], 20'h55AA1, 4'b0101, 2'b10));
    run(ea, 0, 1);
    chk("R6 real address", gotRa, {20'h55AA1, 12'h123});
    chk("R6 wimg", {28'b0, gotWimg}, 32'h5);
    chk("R6 pp", {30'b0, gotPp}, 32'h2);
    chk("R4 single read on entry 0 hit", gotReads, 1);
    chk("R11 problem key", {31'b0, gotKey}, 32'd1);
    chk("R1 no fault", {31'b0, gotFault}, 32'd0);
    chk("R10 busy continuous", {31'b0, busyGap}, 32'd0);
  endtask

  task automatic tLaterEntry;
    logic [31:0] ea = 32'h7123_4FED;
    logic [31:0] g;
    tabCount = 0;
    g = grp(DESC0, VS7, ea, 0);
    put(g + 0,  pte(0, VS7, 0, ea[27:22], 20'h11111, 4'h1, 2'b01));
    put(g + 8,  pte(1, VS7, 1, ea[27:22], 20'h22222, 4'h2, 2'b01));
    put(g + 16, pte(1, VS7 ^ 24'h800000, 0, ea[27:22], 20'h33333, 4'h3, 2'b01));
    put(g + 24, pte(1, VS7, 0, ea[27:22] ^ 6'h20, 20'h44444, 4'h4, 2'b01));
    put(g + 32, pte(1, VS7, 0, ea[27:22] ^ 6'h01, 20'h44445, 4'h4, 2'b01));
    put(g + 40, pte(1, VS7, 0, ea[27:22], 20'hABCDE, 4'hA, 2'b11));
    put(g + 48, pte(1, VS7, 0, ea[27:22], 20'h66666, 4'h6, 2'b00));
    run(ea, 0, 0);
    chk("R3 decoys skipped, entry 5 used", gotRa, {20'hABCDE, 12'hFED});
    chk("R4 stops at first match (6 reads)", gotReads, 6);
    chk("R11 supervisor key", {31'b0, gotKey}, 32'd1);
    chk("R1 segment 7 selected, no fault", {31'b0, gotFault}, 32'd0);
  endtask

  task automatic tSecondary;
    logic [31:0] ea = 32'h3456_7ABC;
    logic [31:0] p, s;
    tabCount = 0;
    p = grp(DESC0, VS3, ea, 0);
    s = grp(DESC0, VS3, ea, 1);
    put(p + 24, pte(1, VS3, 1, ea[27:22], 20'h99999, 4'h9, 2'b01));
    put(s + 8,  pte(1, VS3, 0, ea[27:22], 20'h88888, 4'h8, 2'b01));
    put(s + 16, pte(1, VS3, 1, ea[27:22], 20'h0F0F0, 4'hC, 2'b01));
    run(ea, 1, 0);
    chk("R5 secondary hit address", gotRa, {20'h0F0F0, 12'hABC});
    chk("R5 secondary wimg", {28'b0, gotWimg}, 32'hC);
    chk("R5 read count 8+3", gotReads, 11);
  endtask

  task automatic tMiss;
    logic [31:0] ea = 32'h3000_5000;
    tabCount = 0;
    run(ea, 1, 0);
    chk("R7 fault on double miss", {31'b0, gotFault}, 32'd1);
    chk("R7 instruction tag", {31'b0, gotFetch}, 32'd1);
    chk("R7 16 reads", gotReads, 16);
    chk("R7 not direct-store", {31'b0, gotDirect}, 32'd0);
    run(ea, 0, 0);
    chk("R7 data tag", {31'b0, gotFetch}, 32'd0);
  endtask

  task automatic tMask;
    logic [31:0] ea = 32'h3F0F_0246;
    logic [31:0] d;
    d = {7'h01, 9'h000, 7'h00, 9'h1FF};
    wrDesc(d);
    tabCount = 0;
    put(grp(d, VS3, ea, 0), pte(1, VS3, 0, ea[27:22], 20'h13579, 4'h3, 2'b10));
    run(ea, 0, 0);
    chk("R2 full mask group address", gotRa, {20'h13579, 12'h246});
    d = {7'h02, 9'h1F0, 7'h00, 9'h00F};
    wrDesc(d);
    tabCount = 0;
    put(grp(d, VS3, ea, 0), pte(1, VS3, 0, ea[27:22], 20'h2468A, 4'h3, 2'b10));
    run(ea, 0, 0);
    chk("R2 partial mask with OR bits", gotRa, {20'h2468A, 12'h246});
    wrDesc(DESC0);
  endtask

  task automatic tDirect;
    run(32'h9000_1234, 0, 0);
    chk("R8 direct-store fault", {31'b0, gotFault}, 32'd1);
    chk("R8 direct flag", {31'b0, gotDirect}, 32'd1);
    chk("R8 no memory reads", gotReads, 0);
  endtask

  task automatic tBlock;
    int startReads;
    bit seen = 0;
    @(negedge clk);
    startReads = readCount;
    reqValid = 1; reqEa = 32'h3ABC_D123; blockHit = 1;
    @(negedge clk);
    reqValid = 0; blockHit = 0;
    for (int i = 0; i < 6; i++) begin
      if (busy || rspValid) seen = 1;
      @(negedge clk);
    end
    chk("R9 no activity on block hit", {31'b0, seen}, 32'd0);
    chk("R9 no reads on block hit", readCount - startReads, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    wrDesc(DESC0);
    wrSeg(3, {3'b001, 5'b0, VS3});
    wrSeg(7, {3'b010, 5'b0, VS7});
    wrSeg(9, {3'b100, 5'b0, 24'h000042});
    tPrimaryFirst();
    tLaterEntry();
    tSecondary();
    tMiss();
    tMask();
    tDirect();
    tBlock();
    tPrimaryFirst();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule